// File: doc/BRIEF.md
# Looping Four-Sample Pattern Player

This block holds a stored test pattern and replays it, row by row, into a converter front end that takes four samples per fast-clock cycle and serialises them 4:1. Each row packs four samples. All four samples of the current row are presented in parallel on every rising edge. A host fills the pattern store through a plain write port and sets the loop length. It then starts and stops playback. While playback runs, the row pointer runs from row 0 to the programmed last row and jumps back to row 0 with no idle cycle. This repeats until a stop arrives.

Two fallback sources let the converter run with no host present. One holds the output at zero. The other is a free-running ramp generator. The source is chosen once, on the first clock after reset, and it stays fixed until the next reset. This keeps the output clean when the board starts up.

Top module: `pat_player`

## Requirements
- R1: The store holds ROWS rows of SMP_N×SMP_W bits, written through `wr_en_i`/`wr_addr_i`/`wr_data_i`. Slot A sits in bits [39:30] and is the first sample in time, followed by B [29:20], C [19:10] and D [9:0]. Reset does not clear the contents.
- R2: On the first clock edge after `rst_ni` rises, the source is latched. Pattern mode is selected if `host_en_i`=1. Otherwise ramp mode is selected if `ramp_en_i`=1. Otherwise zero mode is selected. Later changes to either input have no effect until the next reset. Before the latch the output is zero.
- R3: In pattern mode, `start_i` restarts playback at row 0, even when playback is already running.
- R4: A pattern of L+1 rows plays rows 0..L and then returns to row 0 on the next cycle, with no gap, indefinitely.
- R5: `len_we_i` stores `len_i` as the row count minus one. Values below MIN_ROWS-1 (3) are stored as 3, and the value after reset is 3.
- R6: In pattern mode, `stop_i` halts playback. On the edge that samples `stop_i`, `smp_o` becomes zero and `vld_o` goes low. `stop_i` wins over a `start_i` in the same cycle.
- R7: Memory or length writes made while playback runs are ignored, and they set `err_o`. `err_o` stays set until reset.
- R8: Reads are registered. The row addressed at one edge appears on `smp_o` at the next edge, so the first row follows one cycle after the edge that samples `start_i`. `vld_o` is high exactly when `smp_o` carries a pattern row or a ramp row.
- R9: Zero mode holds `smp_o` at 0 and `vld_o` low, and it ignores `start_i`.
- R10: Ramp mode gives row n the values 4n+1, 4n+2, 4n+3 and 4n+4 (mod 1024) in slots A..D. Row 0 appears on the second edge after reset release with `vld_o` high. The ramp ignores `start_i` and `stop_i`.
- R11: While in reset, `smp_o`=0, `vld_o`=0 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_en_i | input | 1 | Select pattern playback (latched after reset) |
| ramp_en_i | input | 1 | Select ramp over zero when not in pattern mode (latched) |
| wr_en_i | input | 1 | Pattern row write strobe |
| wr_addr_i | input | AW | Row address for writes |
| wr_data_i | input | ROW_W | Row data, slot A in the top bits |
| len_we_i | input | 1 | Length write strobe |
| len_i | input | AW | Row count minus one |
| start_i | input | 1 | Start or restart playback at row 0 |
| stop_i | input | 1 | Stop playback and zero the output |
| smp_o | output | ROW_W | Four samples of the current row |
| vld_o | output | 1 | Output carries a pattern or ramp row |
| err_o | output | 1 | Sticky flag for a write attempted during playback |

## Verification
The bench builds the block with its default parameters: 512 rows of four 10-bit samples and a minimum pattern of four rows. With these values, a single run can exercise a full-depth loop that wraps from row 511 to row 0. It can also reach a 10-bit ramp wrap (row 255 ends in 0, and row 256 starts again at 1) and the clamp of short lengths to four rows. Separate resets with different selector settings cover each of the three sources and the locking of the mode after reset.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [1:0] {
    MODE_ZERO = 2'd0,
    MODE_RAMP = 2'd1,
    MODE_PAT  = 2'd2
  } play_mode_e;
endpackage

// File: rtl/pat_mem.sv
module pat_mem #(
  parameter int ROWS  = 512,
  parameter int ROW_W = 40,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ROW_W-1:0] rdata_o
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rd_q <= mem[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/pat_seq.sv
module pat_seq #(
  parameter int ROWS     = 512,
  parameter int MIN_ROWS = 4,
  localparam int AW      = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          len_we_i,
  input  logic [AW-1:0] len_i,
  input  logic          wr_req_i,
  output logic          run_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] last_o,
  output logic          out_vld_o,
  output logic          wr_ok_o,
  output logic          err_o
);
  localparam logic [AW-1:0] LAST_MIN = AW'(MIN_ROWS - 1);

  logic          run_q, vld_q, err_q;
  logic [AW-1:0] row_q, last_q;
  logic          do_stop, do_start;

  assign do_stop  = en_i & stop_i;
  assign do_start = en_i & start_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      row_q  <= '0;
      last_q <= LAST_MIN;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (do_stop) begin
        run_q <= 1'b0;
      end else if (do_start) begin
        run_q <= 1'b1;
        row_q <= '0;
      end else if (run_q) begin
        row_q <= (row_q == last_q) ? '0 : row_q + 1'b1;
      end
      vld_q <= run_q & ~do_stop;
      if (len_we_i && !run_q) last_q <= (len_i < LAST_MIN) ? LAST_MIN : len_i;
      if ((len_we_i || wr_req_i) && run_q) err_q <= 1'b1;
    end
  end

  assign run_o     = run_q;
  assign row_o     = row_q;
  assign last_o    = last_q;
  assign out_vld_o = vld_q;
  assign wr_ok_o   = wr_req_i & ~run_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pat_ramp.sv
module pat_ramp #(
  parameter int SMP_W = 10,
  parameter int SMP_N = 4,
  localparam int ROW_W = SMP_W * SMP_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [ROW_W-1:0] data_o,
  output logic             vld_o
);
  logic [SMP_W-1:0] base_q;
  logic [ROW_W-1:0] nxt, out_q;
  logic             vld_q;

  // slot 0 (first in time) in the top bits
  for (genvar g = 0; g < SMP_N; g++) begin : g_slot
    assign nxt[(SMP_N-1-g)*SMP_W +: SMP_W] = base_q + SMP_W'(g + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else if (en_i) begin
      base_q <= base_q + SMP_W'(SMP_N);
      out_q  <= nxt;
      vld_q  <= 1'b1;
    end else begin
      base_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end
  end

  assign data_o = out_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/pat_player.sv
module pat_player
  import pat_pkg::*;
#(
  parameter int ROWS     = 512,
  parameter int SMP_W    = 10,
  parameter int SMP_N    = 4,
  parameter int MIN_ROWS = 4,
  localparam int AW      = $clog2(ROWS),
  localparam int ROW_W   = SMP_W * SMP_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_en_i,
  input  logic             ramp_en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [ROW_W-1:0] wr_data_i,
  input  logic             len_we_i,
  input  logic [AW-1:0]    len_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [ROW_W-1:0] smp_o,
  output logic             vld_o,
  output logic             err_o
);
  play_mode_e       mode_q;
  logic             lock_q;
  logic             run_w, pat_vld, wr_ok, ramp_vld;
  logic [AW-1:0]    row_w, last_w;
  logic [ROW_W-1:0] rd_data, ramp_data;

  // source is fixed on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ZERO;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      lock_q <= 1'b1;
      mode_q <= host_en_i ? MODE_PAT : (ramp_en_i ? MODE_RAMP : MODE_ZERO);
    end
  end

  pat_seq #(.ROWS(ROWS), .MIN_ROWS(MIN_ROWS)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode_q == MODE_PAT),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .len_we_i (len_we_i),
    .len_i    (len_i),
    .wr_req_i (wr_en_i),
    .run_o    (run_w),
    .row_o    (row_w),
    .last_o   (last_w),
    .out_vld_o(pat_vld),
    .wr_ok_o  (wr_ok),
    .err_o    (err_o)
  );

  pat_mem #(.ROWS(ROWS), .ROW_W(ROW_W)) i_mem (
    .clk_i  (clk_i),
    .we_i   (wr_ok),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i),
    .raddr_i(row_w),
    .rdata_o(rd_data)
  );

  pat_ramp #(.SMP_W(SMP_W), .SMP_N(SMP_N)) i_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mode_q == MODE_RAMP),
    .data_o(ramp_data),
    .vld_o (ramp_vld)
  );

  always_comb begin
    if (pat_vld)       smp_o = rd_data;
    else if (ramp_vld) smp_o = ramp_data;
    else               smp_o = '0;
  end
  assign vld_o = pat_vld | ramp_vld;
endmodule

// File: rtl/pat_player_chk.sv
module pat_player_chk
  import pat_pkg::*;
#(
  parameter int AW    = 9,
  parameter int ROW_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             wr_en_i,
  input logic             len_we_i,
  input play_mode_e       mode_q,
  input logic             lock_q,
  input logic             run_q,
  input logic [AW-1:0]    row_q,
  input logic [AW-1:0]    last_q,
  input logic [ROW_W-1:0] smp_o,
  input logic             vld_o,
  input logic             err_o
);
  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(mode_q)); // R2

  AST_START_ROW0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PAT && start_i && !stop_i) |=> (run_q && row_q == '0)); // R3

  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && !stop_i && row_q == last_q) |=> (row_q == '0)); // R4

  AST_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q >= AW'(3)); // R5

  AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PAT && stop_i) |=> (smp_o == '0 && !vld_o)); // R6

  AST_WR_RUN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || len_we_i) && run_q) |=> err_o); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7

  AST_ZERO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ZERO) |-> (!vld_o && smp_o == '0)); // R9
endmodule

bind pat_player pat_player_chk #(.AW(AW), .ROW_W(ROW_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .stop_i  (stop_i),
  .wr_en_i (wr_en_i),
  .len_we_i(len_we_i),
  .mode_q  (mode_q),
  .lock_q  (lock_q),
  .run_q   (run_w),
  .row_q   (row_w),
  .last_q  (last_w),
  .smp_o   (smp_o),
  .vld_o   (vld_o),
  .err_o   (err_o)
);

// File: tb/test_pat_player.sv
module test_pat_player;
  localparam int AW = 9;
  localparam int RW = 40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_en_i = 1'b0, ramp_en_i = 1'b0;
  logic          wr_en_i = 1'b0, len_we_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, len_i = '0;
  logic [RW-1:0] wr_data_i = '0;
  logic [RW-1:0] smp_o;
  logic          vld_o, err_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pat_player i_pat_player (
    .clk_i(clk), .rst_ni(rst_ni), .host_en_i(host_en_i), .ramp_en_i(ramp_en_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .len_we_i(len_we_i), .len_i(len_i), .start_i(start_i), .stop_i(stop_i),
    .smp_o(smp_o), .vld_o(vld_o), .err_o(err_o)
  );

  function automatic logic [RW-1:0] row_val(input int i);
    return {10'(i * 7 + 3), 10'(i ^ 10'h2AA), 10'(~i), 10'(i + 100)};
  endfunction

  function automatic logic [RW-1:0] ramp_val(input int n);
    return {10'(4*n + 1), 10'(4*n + 2), 10'(4*n + 3), 10'(4*n + 4)};
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic host, input logic ramp);
    rst_ni = 1'b0;
    host_en_i = host; ramp_en_i = ramp;
    wr_en_i = 0; len_we_i = 0; start_i = 0; stop_i = 0;
    tick(); tick();
    check("R11 smp in reset", smp_o, '0);
    check("R11 vld in reset", RW'(vld_o), '0);
    check("R11 err in reset", RW'(err_o), '0);
    rst_ni = 1'b1;
    tick();
    check("R2 zero before source latch", smp_o, '0);
  endtask

  task automatic wr_row(input int a, input logic [RW-1:0] d);
    wr_en_i = 1; wr_addr_i = AW'(a); wr_data_i = d;
    tick();
    wr_en_i = 0;
  endtask

  task automatic wr_len(input int l);
    len_we_i = 1; len_i = AW'(l);
    tick();
    len_we_i = 0;
  endtask

  task automatic pulse_start();
    start_i = 1; tick(); start_i = 0;
  endtask

  task automatic pulse_stop();
    stop_i = 1; tick(); stop_i = 0;
  endtask

  task automatic t_pattern();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) wr_row(i, row_val(i));
    wr_len(5);
    pulse_start();
    check("R8 no valid on start edge", RW'(vld_o), '0);
    for (int k = 0; k < 14; k++) begin
      tick();
      check("R4 R1 loop row", smp_o, row_val(k % 6));
      check("R8 valid during play", RW'(vld_o), 1);
    end
    pulse_start();
    check("R3 restart edge shows pending row", smp_o, row_val(2));
    tick();
    check("R3 restart at row 0", smp_o, row_val(0));
    wr_row(0, 40'h12345_6789A);
    check("R7 err after write in play", RW'(err_o), 1);
    wr_len(1);
    pulse_stop();
    check("R6 smp zero after stop", smp_o, '0);
    check("R6 vld low after stop", RW'(vld_o), '0);
    tick();
    check("R6 stays zero", smp_o, '0);
    check("R7 err sticky", RW'(err_o), 1);
    pulse_start();
    for (int k = 0; k < 8; k++) begin
      tick();
      check("R7 ignored writes, 6-row loop", smp_o, row_val(k % 6));
    end
    stop_i = 1; start_i = 1; tick(); stop_i = 0; start_i = 0;
    check("R6 stop wins over start", RW'(vld_o), '0);
    tick();
    check("R6 still stopped", smp_o, '0);
  endtask

  task automatic t_clamp();
    wr_len(1);
    pulse_start();
    for (int k = 0; k < 10; k++) begin
      tick();
      check("R5 short length clamped to 4 rows", smp_o, row_val(k % 4));
    end
    pulse_stop();
    do_reset(1'b1, 1'b0);
    check("R11 err cleared by reset", RW'(err_o), '0);
    pulse_start();
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R5 R1 reset length, contents kept", smp_o, row_val(k % 4));
    end
    pulse_stop();
  endtask

  task automatic t_full();
    for (int i = 0; i < 512; i++) wr_row(i, row_val(i));
    wr_len(511);
    pulse_start();
    for (int k = 0; k < 516; k++) begin
      tick();
      check("R4 full depth wrap", smp_o, row_val(k % 512));
    end
    pulse_stop();
  endtask

  task automatic t_ramp();
    do_reset(1'b0, 1'b1);
    for (int n = 0; n < 260; n++) begin
      if (n == 100) begin host_en_i = 1; ramp_en_i = 0; stop_i = 1; end
      if (n == 101) begin stop_i = 0; start_i = 1; end
      if (n == 102) start_i = 0;
      tick();
      check("R10 R2 ramp row", smp_o, ramp_val(n));
      check("R10 ramp valid", RW'(vld_o), 1);
    end
  endtask

  task automatic t_zero();
    do_reset(1'b0, 1'b0);
    ramp_en_i = 1;
    start_i = 1;
    for (int k = 0; k < 5; k++) begin
      tick();
      start_i = 0;
      check("R9 R2 zero mode output", smp_o, '0);
      check("R9 zero mode valid", RW'(vld_o), '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_pattern();
    t_clamp();
    t_full();
    t_ramp();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule